// File: doc/BRIEF.md
# Serial Controller Event Flag and Interrupt Register

This block gathers the sticky event flags of a combined UART/LIN serial controller into one 32-bit status word. A small register bus reads and writes it. The receiver and the LIN protocol engine report events as single-cycle pulses, and each pulse latches a flag. A flag stays set until software writes a one to its bit. A per-flag enable word selects which flags raise the single interrupt request line.

The block also keeps the one-byte receive holding register. This register decides when an overrun happens. A completed frame is loaded only when the holding register is empty, or when it is being read in the same cycle. Otherwise the new byte is discarded, the byte already held is kept, and the overrun flag is raised.

Register map (address `bus_addr`): 0 is the status word, 1 is the enable word, and 2 is the received byte, zero-extended. Address 3 reads zero. Read data appears on `bus_rdata` in the cycle after `bus_rd`. A read at address 2 empties the holding register.

Top module: `sci_flag_status`

## Requirements
- R1: After reset, the status word, the enable word, `irq` and `bus_rdata` are all zero, and the holding register is empty.
- R2: Each event sets its own status bit one clock after its pulse. The bits are: overrun 4, noise 5, framing 6, parity 7, LIN bit error 11, LIN rx ready 16, LIN tx ready 17, LIN wake-up 18, LIN slave timeout 19, LIN physical bus error 20, LIN CRC error 21.
- R3: Writing the status word clears every flag whose bit is written as 1. Bits written as 0 keep their value.
- R4: When a set pulse and a write-one-to-clear reach the same flag in the same cycle, the flag stays set.
- R5: A frame that completes while the holding register is full and is not being read sets bit 4. The new byte is dropped, and the held byte is still returned by the next data read.
- R6: A frame that completes in the same cycle as a data read is accepted without overrun. The read returns the old byte, and the following read returns the new one.
- R7: At frame completion, a stop-bit sample of 0 sets bit 6. A sample of 1 leaves bit 6 clear.
- R8: The wake-up pulse sets bit 18 only while `lin_sleep` is 1. Otherwise the pulse has no effect.
- R9: `irq` is 1 one clock after any flag is set whose enable bit is also set. It returns to 0 one clock after no enabled flag remains.
- R10: Status and enable bits outside {4..7, 11, 16..21} always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rx_frame_done | input | 1 | Receive frame completed (pulse) |
| rx_frame_byte | input | 8 | Byte of the completed frame |
| rx_stop_sample | input | 1 | Sampled stop-bit level of the completed frame |
| ev_noise | input | 1 | Noise detected pulse |
| ev_parity | input | 1 | Parity mismatch pulse |
| ev_lin_bit | input | 1 | LIN readback bit error pulse |
| ev_lin_rx_ready | input | 1 | LIN data byte received pulse |
| ev_lin_tx_ready | input | 1 | LIN ready for next byte pulse |
| ev_lin_wake | input | 1 | LIN wake-up character pulse |
| lin_sleep | input | 1 | LIN bus is in sleep mode |
| ev_lin_slave_to | input | 1 | LIN slave response timeout pulse |
| ev_lin_phys | input | 1 | LIN physical bus error pulse |
| ev_lin_crc | input | 1 | LIN CRC mismatch pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the full-buffer case in two ways. First it lets a second frame arrive unread. A design that overwrote the buffer would then return the newer byte. Then it completes a frame in the same cycle as a data read. A design that did not treat the read as freeing the buffer would raise a spurious overrun and lose the new byte. It also fires a parity pulse and a write-one-to-clear at the same edge, where a design giving priority to the clear would drop the event. Finally it sends a wake-up pulse outside sleep and writes all ones to the unused bits, where a leaky mask shows up as stray status or enable bits.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 2;

  localparam int unsigned POS_OVR   = 4;
  localparam int unsigned POS_NOISE = 5;
  localparam int unsigned POS_FRAME = 6;
  localparam int unsigned POS_PAR   = 7;
  localparam int unsigned POS_LBIT  = 11;
  localparam int unsigned POS_LRXR  = 16;
  localparam int unsigned POS_LTXR  = 17;
  localparam int unsigned POS_LWAKE = 18;
  localparam int unsigned POS_LSTO  = 19;
  localparam int unsigned POS_LPHY  = 20;
  localparam int unsigned POS_LCRC  = 21;

  typedef logic [REG_W-1:0] word_t;

  localparam word_t FLAG_MASK =
    (word_t'(1) << POS_OVR)   | (word_t'(1) << POS_NOISE) |
    (word_t'(1) << POS_FRAME) | (word_t'(1) << POS_PAR)   |
    (word_t'(1) << POS_LBIT)  | (word_t'(1) << POS_LRXR)  |
    (word_t'(1) << POS_LTXR)  | (word_t'(1) << POS_LWAKE) |
    (word_t'(1) << POS_LSTO)  | (word_t'(1) << POS_LPHY)  |
    (word_t'(1) << POS_LCRC);

  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS = 2'd0,
    RA_ENABLE = 2'd1,
    RA_DATA   = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sflag_rx_hold.sv
module sflag_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic              data_read,
  output logic [DATA_W-1:0] hold_byte,
  output logic              overrun_evt
);
  logic              full_q;
  logic [DATA_W-1:0] hold_q;
  logic              accept;

  // a frame may enter when the slot is empty or is being emptied now
  assign accept      = frame_done && (!full_q || data_read);
  assign overrun_evt = frame_done && full_q && !data_read;
  assign hold_byte   = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (accept) begin
        hold_q <= frame_byte;
        full_q <= 1'b1;
      end else if (data_read) begin
        full_q <= 1'b0;
      end
    end
  end

  // R5: dropped frame leaves the held byte untouched
  a_r5_hold_kept: assert property (@(posedge clk) disable iff (rst)
    (frame_done && full_q && !data_read) |=> ($stable(hold_q) && full_q));

  // R6: read in the same cycle makes room for the new byte
  a_r6_read_frees: assert property (@(posedge clk) disable iff (rst)
    (frame_done && data_read) |=> (full_q && hold_q == $past(frame_byte)));
endmodule

// File: rtl/sflag_bank.sv
module sflag_bank #(
  parameter int unsigned              W    = 32,
  parameter logic [W-1:0]             MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk) begin
        if (rst)              flag_q <= 1'b0;
        else if (set_vec[i])  flag_q <= 1'b1;   // set has priority
        else if (clr_vec[i])  flag_q <= 1'b0;
      end
      assign flags[i] = flag_q;

      // R4: a set pulse always leaves the flag set
      a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> flags[i]);
      // R3: clear without set removes the flag
      a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_vec[i] && !set_vec[i]) |=> !flags[i]);
    end else begin : g_none
      assign flags[i] = 1'b0;
    end
  end

  // R10: unimplemented bits are never 1
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (flags & ~MASK) == '0);
endmodule

// File: rtl/sflag_irq.sv
module sflag_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] enables,
  output logic         irq
);
  logic irq_q;
  logic any_enabled;

  assign any_enabled = |(flags & enables);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any_enabled;
  end
  assign irq = irq_q;

  // R9: request follows enabled flags one clock later
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
    any_enabled |=> irq);
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !any_enabled |=> !irq);
endmodule

// File: rtl/sci_flag_status.sv
module sci_flag_status
  import sflag_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned AW     = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              rx_frame_done,
  input  logic [DATA_W-1:0] rx_frame_byte,
  input  logic              rx_stop_sample,
  input  logic              ev_noise,
  input  logic              ev_parity,
  input  logic              ev_lin_bit,
  input  logic              ev_lin_rx_ready,
  input  logic              ev_lin_tx_ready,
  input  logic              ev_lin_wake,
  input  logic              lin_sleep,
  input  logic              ev_lin_slave_to,
  input  logic              ev_lin_phys,
  input  logic              ev_lin_crc,
  output logic              irq
);
  localparam int unsigned PAD_W = REG_W - DATA_W;

  word_t             status;
  word_t             set_vec;
  word_t             clr_vec;
  word_t             en_q;
  word_t             rdata_q;
  logic [DATA_W-1:0] hold_byte;
  logic              overrun_evt;
  logic              data_read;
  logic              wake_evt;

  assign data_read = bus_rd && (bus_addr == AW'(RA_DATA));
  assign wake_evt  = ev_lin_wake && lin_sleep;

  sflag_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .frame_done  (rx_frame_done),
    .frame_byte  (rx_frame_byte),
    .data_read   (data_read),
    .hold_byte   (hold_byte),
    .overrun_evt (overrun_evt)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[POS_OVR]   = overrun_evt;
    set_vec[POS_NOISE] = ev_noise;
    set_vec[POS_FRAME] = rx_frame_done && !rx_stop_sample;
    set_vec[POS_PAR]   = ev_parity;
    set_vec[POS_LBIT]  = ev_lin_bit;
    set_vec[POS_LRXR]  = ev_lin_rx_ready;
    set_vec[POS_LTXR]  = ev_lin_tx_ready;
    set_vec[POS_LWAKE] = wake_evt;
    set_vec[POS_LSTO]  = ev_lin_slave_to;
    set_vec[POS_LPHY]  = ev_lin_phys;
    set_vec[POS_LCRC]  = ev_lin_crc;
  end

  assign clr_vec = (bus_wr && bus_addr == AW'(RA_STATUS)) ? bus_wdata : '0;

  sflag_bank #(.W(REG_W), .MASK(FLAG_MASK)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (status)
  );

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (bus_wr && bus_addr == AW'(RA_ENABLE))
      en_q <= bus_wdata & FLAG_MASK;
  end

  sflag_irq #(.W(REG_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .flags   (status),
    .enables (en_q),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        AW'(RA_STATUS): rdata_q <= status;
        AW'(RA_ENABLE): rdata_q <= en_q;
        AW'(RA_DATA):   rdata_q <= {{PAD_W{1'b0}}, hold_byte};
        default:        rdata_q <= '0;
      endcase
    end
  end
  assign bus_rdata = rdata_q;

  // R8: wake-up flag rises only from an event taken during sleep
  a_r8_wake_sleep_only: assert property (@(posedge clk) disable iff (rst)
    $rose(status[POS_LWAKE]) |-> $past(lin_sleep));

  // R10: enable word never holds unimplemented bits
  a_r10_enable_masked: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~FLAG_MASK) == '0);

  // R7: stop bit sampled low latches framing error
  a_r7_framing: assert property (@(posedge clk) disable iff (rst)
    (rx_frame_done && !rx_stop_sample) |=> status[POS_FRAME]);
endmodule

// File: tb/test_sci_flag_status.sv
module test_sci_flag_status;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        rx_frame_done;
  logic [7:0]  rx_frame_byte;
  logic        rx_stop_sample;
  logic        ev_noise, ev_parity, ev_lin_bit, ev_lin_rx_ready, ev_lin_tx_ready;
  logic        ev_lin_wake, lin_sleep, ev_lin_slave_to, ev_lin_phys, ev_lin_crc;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  sci_flag_status i_sci_flag_status (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_frame_done(rx_frame_done), .rx_frame_byte(rx_frame_byte),
    .rx_stop_sample(rx_stop_sample), .ev_noise(ev_noise), .ev_parity(ev_parity),
    .ev_lin_bit(ev_lin_bit), .ev_lin_rx_ready(ev_lin_rx_ready),
    .ev_lin_tx_ready(ev_lin_tx_ready), .ev_lin_wake(ev_lin_wake),
    .lin_sleep(lin_sleep), .ev_lin_slave_to(ev_lin_slave_to),
    .ev_lin_phys(ev_lin_phys), .ev_lin_crc(ev_lin_crc), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_addr = 2'd0; bus_wr = 0; bus_wdata = '0; bus_rd = 0;
    rx_frame_done = 0; rx_frame_byte = '0; rx_stop_sample = 1;
    ev_noise = 0; ev_parity = 0; ev_lin_bit = 0; ev_lin_rx_ready = 0;
    ev_lin_tx_ready = 0; ev_lin_wake = 0; lin_sleep = 0;
    ev_lin_slave_to = 0; ev_lin_phys = 0; ev_lin_crc = 0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic frame(input logic [7:0] b, input logic stop);
    @(negedge clk);
    rx_frame_done = 1; rx_frame_byte = b; rx_stop_sample = stop;
    @(negedge clk);
    rx_frame_done = 0; rx_stop_sample = 1;
  endtask

  task automatic pulse_event(input int sel);
    @(negedge clk);
    case (sel)
      5:  ev_noise = 1;
      7:  ev_parity = 1;
      11: ev_lin_bit = 1;
      16: ev_lin_rx_ready = 1;
      17: ev_lin_tx_ready = 1;
      18: ev_lin_wake = 1;
      19: ev_lin_slave_to = 1;
      20: ev_lin_phys = 1;
      21: ev_lin_crc = 1;
      default: ;
    endcase
    @(negedge clk);
    ev_noise = 0; ev_parity = 0; ev_lin_bit = 0; ev_lin_rx_ready = 0;
    ev_lin_tx_ready = 0; ev_lin_wake = 0; ev_lin_slave_to = 0;
    ev_lin_phys = 0; ev_lin_crc = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    reg_read(2'd0, v); check("R1 status", v, 32'h0);
    reg_read(2'd1, v); check("R1 enable", v, 32'h0);
  endtask

  task automatic t_positions();
    logic [31:0] v;
    int ids[9] = '{5, 7, 11, 16, 17, 19, 20, 21, 18};
    lin_sleep = 1;
    foreach (ids[k]) begin
      pulse_event(ids[k]);
      reg_read(2'd0, v);
      check($sformatf("R2 bit %0d", ids[k]), v, 32'h1 << ids[k]);
      reg_write(2'd0, 32'h1 << ids[k]);
    end
    lin_sleep = 0;
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    pulse_event(5); pulse_event(16); pulse_event(21);
    reg_write(2'd0, 32'h0000_0000);
    reg_read(2'd0, v); check("R3 zero write keeps", v, 32'h0021_0020);
    reg_write(2'd0, 32'h0001_0000);
    reg_read(2'd0, v); check("R3 partial clear", v, 32'h0020_0020);
    reg_write(2'd0, 32'hFFFF_FFFF);
    reg_read(2'd0, v); check("R3 full clear", v, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    pulse_event(7);
    @(negedge clk);
    ev_parity = 1; bus_addr = 2'd0; bus_wdata = 32'h80; bus_wr = 1;
    @(negedge clk);
    ev_parity = 0; bus_wr = 0; bus_wdata = '0;
    reg_read(2'd0, v); check("R4 set beats clear", v, 32'h80);
    reg_write(2'd0, 32'h80);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    frame(8'hA5, 1);
    frame(8'h3C, 1);
    reg_read(2'd0, v); check("R5 overrun flag", v, 32'h10);
    reg_read(2'd2, v); check("R5 held byte kept", v, 32'hA5);
    reg_write(2'd0, 32'h10);
  endtask

  task automatic t_read_and_frame();
    logic [31:0] v;
    frame(8'h11, 1);
    @(negedge clk);
    bus_addr = 2'd2; bus_rd = 1;
    rx_frame_done = 1; rx_frame_byte = 8'h22;
    @(negedge clk);
    bus_rd = 0; rx_frame_done = 0;
    check("R6 old byte read", bus_rdata, 32'h11);
    reg_read(2'd2, v); check("R6 new byte", v, 32'h22);
    reg_read(2'd0, v); check("R6 no overrun", v, 32'h0);
  endtask

  task automatic t_framing();
    logic [31:0] v;
    frame(8'h01, 1);
    reg_read(2'd0, v); check("R7 good stop", v, 32'h0);
    reg_read(2'd2, v);
    frame(8'h02, 0);
    reg_read(2'd0, v); check("R7 bad stop", v, 32'h40);
    reg_read(2'd2, v);
    reg_write(2'd0, 32'h40);
  endtask

  task automatic t_wake();
    logic [31:0] v;
    lin_sleep = 0;
    pulse_event(18);
    reg_read(2'd0, v); check("R8 awake ignored", v, 32'h0);
    lin_sleep = 1;
    pulse_event(18);
    reg_read(2'd0, v); check("R8 sleep sets", v, 32'h0004_0000);
    lin_sleep = 0;
    reg_write(2'd0, 32'h0004_0000);
  endtask

  task automatic t_irq();
    pulse_event(19);
    check("R9 disabled flag no irq", {31'b0, irq}, 32'h0);
    reg_write(2'd1, 32'h0000_0020);
    check("R9 other enable no irq", {31'b0, irq}, 32'h0);
    pulse_event(5);
    check("R9 before register", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 asserted", {31'b0, irq}, 32'h1);
    reg_write(2'd0, 32'h20);
    check("R9 still high one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R9 dropped", {31'b0, irq}, 32'h0);
    reg_write(2'd0, 32'h0008_0000);
    reg_write(2'd1, 32'h0);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_read(2'd1, v); check("R10 enable mask", v, 32'h003F_08F0);
    reg_write(2'd1, 32'h0);
    reg_read(2'd0, v); check("R10 status unused", v, 32'h0);
    reg_read(2'd3, v); check("R10 spare address", v, 32'h0);
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_positions();
    t_w1c();
    t_set_wins();
    t_overrun();
    t_read_and_frame();
    t_framing();
    t_wake();
    t_irq();
    t_unused();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule